// File: doc/BRIEF.md
# Hardwired Counter-Based Control Sequencer

This block is the control unit of a small accumulator machine. A 4-bit state counter selects the current control step. A 4-to-16 one-hot decoder turns the count into state lines, and combinational logic turns those lines into the datapath strobes: register loads, increments, bus enables, the ALU select and the memory read.

Each instruction begins with three fetch steps at counts 0, 1 and 2, reached by incrementing the counter. On the last fetch step the counter is loaded with an entry code built from the 2-bit opcode register. The code has the form 1, opcode[1], opcode[0], 0. Each execute routine then steps forward, or clears the counter to go back to the first fetch step. Clearing is the only way back, so the seven decoder outputs that no step uses also clear the counter.

Top module: `ctl_sequencer`

## Requirements
- R1: A synchronous active-high `rst` forces `state` to 0 at the next rising edge, whatever the current step, and overrides the opcode-derived load.
- R2: Count 0 is followed by count 1, and count 1 is followed by count 2.
- R3: Count 2 is followed by the code {1, opcode[1], opcode[0], 0}, using the opcode sampled at that edge. Opcode 00 gives 8 (add), 01 gives 10 (and), 10 gives 12 (jump) and 11 gives 14 (increment).
- R4: Count 8 is followed by 9, and count 10 is followed by 11.
- R5: Counts 9, 11, 12 and 14, and every count no step uses (3 to 7, 13, 15), are followed by count 0.
- R6: `pc_load` is high only in count 12. `pc_inc` is high only in count 1. `pc_bus_en` is high only in count 0.
- R7: `dr_load`, `mem_bus_en` and `mem_read` are each high exactly in counts 1, 8 and 10.
- R8: `ac_load` is high exactly in counts 9 and 11. `ac_inc` is high only in count 14. `alu_sel` is high only in count 11.
- R9: `ar_load` is high in counts 0 and 2. `ir_load` is high only in count 2. `dr_bus_en` is high in counts 2, 9, 11 and 12.
- R10: `opcode` has no effect on the next count in any step other than count 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 2 | Contents of the opcode register |
| state | output | 4 | Current step count |
| pc_load | output | 1 | Load program counter from internal bus |
| pc_inc | output | 1 | Increment program counter |
| pc_bus_en | output | 1 | Program counter drives internal bus |
| ar_load | output | 1 | Load address register |
| dr_load | output | 1 | Load data register |
| dr_bus_en | output | 1 | Data register drives internal bus |
| ac_load | output | 1 | Load accumulator from ALU |
| ac_inc | output | 1 | Increment accumulator |
| ir_load | output | 1 | Load opcode register |
| alu_sel | output | 1 | ALU select: high for AND, low for add |
| mem_bus_en | output | 1 | Memory drives internal bus |
| mem_read | output | 1 | Memory read strobe |

## Verification
Reset and the opcode-derived load can fall in the same cycle. The bench provokes this by raising reset with high probability while the sequencer sits in count 2, so that both act at the same edge. The case is judged correct when the next count is 0 and not the entry code. At that same step, the address-register load, the opcode-register load and the data-register bus enable are checked to be high together, in the cycle that also performs the counter load.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int OPW = 2;
    localparam int CW  = OPW + 2;
    localparam int NST = 1 << CW;

    typedef logic [CW-1:0]  cnt_t;
    typedef logic [OPW-1:0] op_t;

    localparam cnt_t ST_FETCH_A = cnt_t'(0);
    localparam cnt_t ST_FETCH_B = cnt_t'(1);
    localparam cnt_t ST_FETCH_C = cnt_t'(2);
    localparam cnt_t ST_SUM_A   = cnt_t'(8);
    localparam cnt_t ST_SUM_B   = cnt_t'(9);
    localparam cnt_t ST_MASK_A  = cnt_t'(10);
    localparam cnt_t ST_MASK_B  = cnt_t'(11);
    localparam cnt_t ST_BRANCH  = cnt_t'(12);
    localparam cnt_t ST_BUMP    = cnt_t'(14);

    typedef struct packed {
        logic pc_load;
        logic pc_inc;
        logic pc_bus_en;
        logic ar_load;
        logic dr_load;
        logic dr_bus_en;
        logic ac_load;
        logic ac_inc;
        logic ir_load;
        logic alu_sel;
        logic mem_bus_en;
        logic mem_read;
    } strobe_t;

    typedef struct packed {
        logic clr;
        logic ld;
        logic inc;
    } cnt_cmd_t;

    // Entry code for an execute routine: MSB set, opcode, LSB clear.
    function automatic cnt_t entry_code(input op_t op);
        return {1'b1, op, 1'b0};
    endfunction

endpackage

// File: rtl/seq_counter.sv
module seq_counter
    import seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cnt_cmd_t cmd,
    input  cnt_t     load_val,
    output cnt_t     count
);
    // Priority: reset, clear, load, increment.
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cmd.clr) begin
            count <= '0;
        end else if (cmd.ld) begin
            count <= load_val;
        end else if (cmd.inc) begin
            count <= count + cnt_t'(1);
        end
    end
endmodule

// File: rtl/seq_decoder.sv
module seq_decoder #(
    parameter int W = 4
) (
    input  logic [W-1:0]      code,
    output logic [(1<<W)-1:0] hot
);
    localparam int N = 1 << W;

    for (genvar i = 0; i < N; i++) begin : g_line
        assign hot[i] = (code == W'(i));
    end
endmodule

// File: rtl/seq_strobes.sv
module seq_strobes
    import seq_pkg::*;
(
    input  logic [NST-1:0] hot,
    output strobe_t        stb,
    output cnt_cmd_t       cmd
);
    logic f_a, f_b, f_c, sum_a, sum_b, mask_a, mask_b, branch, bump;
    logic known;

    always_comb begin
        f_a    = hot[ST_FETCH_A];
        f_b    = hot[ST_FETCH_B];
        f_c    = hot[ST_FETCH_C];
        sum_a  = hot[ST_SUM_A];
        sum_b  = hot[ST_SUM_B];
        mask_a = hot[ST_MASK_A];
        mask_b = hot[ST_MASK_B];
        branch = hot[ST_BRANCH];
        bump   = hot[ST_BUMP];
        known  = f_a | f_b | f_c | sum_a | sum_b | mask_a | mask_b | branch | bump;
    end

    always_comb begin
        stb            = '0;
        stb.pc_load    = branch;
        stb.pc_inc     = f_b;
        stb.pc_bus_en  = f_a;
        stb.ar_load    = f_a | f_c;
        stb.dr_load    = f_b | sum_a | mask_a;
        stb.dr_bus_en  = f_c | sum_b | mask_b | branch;
        stb.ac_load    = sum_b | mask_b;
        stb.ac_inc     = bump;
        stb.ir_load    = f_c;
        stb.alu_sel    = mask_b;
        stb.mem_bus_en = f_b | sum_a | mask_a;
        stb.mem_read   = f_b | sum_a | mask_a;
    end

    // Unused codes fall back to fetch through clear.
    always_comb begin
        cmd.inc = f_a | f_b | sum_a | mask_a;
        cmd.ld  = f_c;
        cmd.clr = sum_b | mask_b | branch | bump | ~known;
    end
endmodule

// File: rtl/ctl_sequencer.sv
module ctl_sequencer
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] opcode,
    output logic [3:0] state,
    output logic       pc_load,
    output logic       pc_inc,
    output logic       pc_bus_en,
    output logic       ar_load,
    output logic       dr_load,
    output logic       dr_bus_en,
    output logic       ac_load,
    output logic       ac_inc,
    output logic       ir_load,
    output logic       alu_sel,
    output logic       mem_bus_en,
    output logic       mem_read
);
    cnt_t           count;
    logic [NST-1:0] hot;
    strobe_t        stb;
    cnt_cmd_t       cmd;
    cnt_t           entry;

    assign entry = entry_code(opcode);

    seq_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .load_val (entry),
        .count    (count)
    );

    seq_decoder #(.W(CW)) u_dec (
        .code (count),
        .hot  (hot)
    );

    seq_strobes u_stb (
        .hot (hot),
        .stb (stb),
        .cmd (cmd)
    );

    assign state      = count;
    assign pc_load    = stb.pc_load;
    assign pc_inc     = stb.pc_inc;
    assign pc_bus_en  = stb.pc_bus_en;
    assign ar_load    = stb.ar_load;
    assign dr_load    = stb.dr_load;
    assign dr_bus_en  = stb.dr_bus_en;
    assign ac_load    = stb.ac_load;
    assign ac_inc     = stb.ac_inc;
    assign ir_load    = stb.ir_load;
    assign alu_sel    = stb.alu_sel;
    assign mem_bus_en = stb.mem_bus_en;
    assign mem_read   = stb.mem_read;
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] opcode,
    input logic [3:0] state,
    input logic       pc_load,
    input logic       pc_inc,
    input logic       pc_bus_en,
    input logic       ar_load,
    input logic       dr_load,
    input logic       dr_bus_en,
    input logic       ac_load,
    input logic       ac_inc,
    input logic       ir_load,
    input logic       alu_sel,
    input logic       mem_bus_en,
    input logic       mem_read
);
    AST_RESET_TO_FETCH: assert property (@(posedge clk) $past(rst) |-> state == 4'd0); // R1
    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst) state == 4'd0 |=> state == 4'd1); // R2
    AST_EXEC_ENTRY: assert property (@(posedge clk) disable iff (rst) state == 4'd2 |=> state == {1'b1, $past(opcode), 1'b0}); // R3
    AST_SUM_STEP: assert property (@(posedge clk) disable iff (rst) state == 4'd8 |=> state == 4'd9); // R4
    AST_RETURN_FETCH: assert property (@(posedge clk) disable iff (rst) (state == 4'd9 || state == 4'd11 || state == 4'd12 || state == 4'd14) |=> state == 4'd0); // R5
    AST_ONE_BUS_DRIVER: assert property (@(posedge clk) disable iff (rst) $onehot0({pc_bus_en, mem_bus_en, dr_bus_en})); // R7
    AST_AC_SINGLE_OP: assert property (@(posedge clk) disable iff (rst) !(ac_load && ac_inc)); // R8
    AST_PC_SINGLE_OP: assert property (@(posedge clk) disable iff (rst) !(pc_load && pc_inc)); // R6
endmodule

bind ctl_sequencer seq_checker u_chk (.*);

// File: tb/ctl_sequencer_tb.sv
module ctl_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] opcode = 2'b00;
    logic [3:0] state;
    logic pc_load, pc_inc, pc_bus_en, ar_load, dr_load, dr_bus_en;
    logic ac_load, ac_inc, ir_load, alu_sel, mem_bus_en, mem_read;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ctl_sequencer u_dut (
        .clk(clk), .rst(rst), .opcode(opcode), .state(state),
        .pc_load(pc_load), .pc_inc(pc_inc), .pc_bus_en(pc_bus_en),
        .ar_load(ar_load), .dr_load(dr_load), .dr_bus_en(dr_bus_en),
        .ac_load(ac_load), .ac_inc(ac_inc), .ir_load(ir_load),
        .alu_sel(alu_sel), .mem_bus_en(mem_bus_en), .mem_read(mem_read)
    );

    // Bit order: pc_load pc_inc pc_bus_en ar_load dr_load dr_bus_en
    //            ac_load ac_inc ir_load alu_sel mem_bus_en mem_read
    function automatic logic [11:0] want_strobes(input logic [3:0] s);
        logic [11:0] v = '0;
        v[11] = (s == 12);
        v[10] = (s == 1);
        v[9]  = (s == 0);
        v[8]  = (s == 0) || (s == 2);
        v[7]  = (s == 1) || (s == 8) || (s == 10);
        v[6]  = (s == 2) || (s == 9) || (s == 11) || (s == 12);
        v[5]  = (s == 9) || (s == 11);
        v[4]  = (s == 14);
        v[3]  = (s == 2);
        v[2]  = (s == 11);
        v[1]  = v[7];
        v[0]  = v[7];
        return v;
    endfunction

    function automatic logic [3:0] want_next(input logic [3:0] s, input logic [1:0] op);
        case (s)
            4'd0:    return 4'd1;
            4'd1:    return 4'd2;
            4'd2:    return {1'b1, op, 1'b0};
            4'd8:    return 4'd9;
            4'd10:   return 4'd11;
            default: return 4'd0;
        endcase
    endfunction

    task automatic check_vec(input string tag, input logic [11:0] got, input logic [11:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic check_cycle(input string st_tag, input logic [3:0] exp_s);
        logic [11:0] got, exp;
        n_chk++;
        if (state !== exp_s) begin
            n_fail++;
            $display("FAIL %s: state got %0d expected %0d", st_tag, state, exp_s);
        end
        got = {pc_load, pc_inc, pc_bus_en, ar_load, dr_load, dr_bus_en,
               ac_load, ac_inc, ir_load, alu_sel, mem_bus_en, mem_read};
        exp = want_strobes(exp_s);
        check_vec("R6 pc strobes",  got & 12'hE00, exp & 12'hE00);
        check_vec("R7 memory/dr",   got & 12'h083, exp & 12'h083);
        check_vec("R8 accumulator", got & 12'h034, exp & 12'h034);
        check_vec("R9 ar/ir/drbus", got & 12'h148, exp & 12'h148);
    endtask

    function automatic string tag_for(input logic [3:0] prev, input bit was_rst);
        if (was_rst) return "R1 reset";
        case (prev)
            4'd0, 4'd1: return "R2 fetch R10";
            4'd2:       return "R3 entry";
            4'd8, 4'd10: return "R4 step R10";
            default:    return "R5 return R10";
        endcase
    endfunction

    initial begin : watchdog
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [3:0] exp_s;
        logic [3:0] prev;
        bit         was_rst;
        int         dir_op;
        void'($urandom(32'h5EED_0042));
        // R1: reset held across the first edge
        @(negedge clk);
        exp_s = 4'd0;
        check_cycle("R1 reset", exp_s);
        rst = 1'b0;
        prev = exp_s; was_rst = 1'b0;
        exp_s = want_next(exp_s, opcode);
        dir_op = 0;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            check_cycle(tag_for(prev, was_rst), exp_s);
            // directed: first four instructions walk opcodes 00..11
            if (cyc < 24) opcode = 2'(dir_op);
            else          opcode = 2'($urandom_range(0, 3));
            if (exp_s == 4'd2 && cyc < 24) dir_op++;
            // reset colliding with the entry load (R1), or rarely elsewhere
            if (cyc >= 24 && exp_s == 4'd2) rst = ($urandom_range(0, 3) == 0);
            else if (cyc >= 24)             rst = ($urandom_range(0, 60) == 0);
            else                            rst = 1'b0;
            prev = exp_s; was_rst = rst;
            exp_s = rst ? 4'd0 : want_next(exp_s, opcode);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule